// File: doc/BRIEF.md
# Flash Boot Image Checker and Loader

The block takes a firmware image stored in byte-addressed flash and prepares it to run from main RAM. The image starts with an 8-byte header that gives the payload length and the checksum the payload should have. After a start pulse, the block reads the header. If the length field is erased, it reports an empty slot at once. Otherwise it reads the payload once to compute its CRC-32. Only when that CRC equals the expected value does it read the payload a second time and write it byte by byte into RAM, starting at the RAM base address. It then raises a jump request that carries that base address.

Each run ends with a one-cycle done pulse. Three status flags form a one-hot set: empty, CRC failure and boot. The flags hold until the next accepted start. Both the computed and the expected checksum stay visible, so a failed check can be diagnosed. The flash port is a synchronous read port with one cycle of latency. The RAM port is a byte write port.

Top module: `boot_image_loader`

## Requirements
- R1: The header occupies flash bytes BOOT_BASE to BOOT_BASE+7. Bytes 0..3 form the payload length and bytes 4..7 form the expected CRC. Both are big-endian, so byte 0 and byte 4 are the most significant bytes.
- R2: A length field of 0xFFFFFFFF ends the run with `st_empty`. Exactly 8 flash reads are made and nothing is written to RAM.
- R3: The checksum is reflected CRC-32 with polynomial 0xEDB88320, initial value 0xFFFFFFFF and a final inversion. It covers exactly the length bytes that follow the header. The payload "123456789" gives 0xCBF43926, and a zero-length payload gives 0x00000000.
- R4: The whole payload is verified before any RAM write. On a mismatch the run ends with `st_crc_fail` and RAM is never written.
- R5: On a match, payload byte i is written once to RAM address RAM_BASE+i, in ascending order. A successful run makes 8+2×length flash reads.
- R6: After the last RAM write, the run ends with `st_boot` high and `jump_addr` equal to RAM_BASE.
- R7: At the end of a failed or successful check, `crc_actual` holds the computed CRC and `crc_expected` holds the header value.
- R8: `done` is a single-cycle pulse. While `done` is high, exactly one of `st_empty`, `st_crc_fail` and `st_boot` is set. The flags hold until the next accepted start. All outputs are low after reset.
- R9: A start pulse while `busy` is high is ignored: it produces no second run and no second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| flash_rd_en | output | 1 | Flash read request |
| flash_rd_addr | output | FLASH_AW | Flash byte address |
| flash_rd_data | input | 8 | Flash byte, valid one cycle after the request |
| ram_wr_en | output | 1 | RAM byte write strobe |
| ram_wr_addr | output | RAM_AW | RAM byte address |
| ram_wr_data | output | 8 | RAM write byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| st_empty | output | 1 | Slot erased, no image |
| st_crc_fail | output | 1 | Checksum mismatch |
| st_boot | output | 1 | Image copied, jump requested |
| jump_addr | output | RAM_AW | Jump target while st_boot is set |
| crc_actual | output | 32 | Computed payload CRC |
| crc_expected | output | 32 | CRC taken from the header |

## Verification
The bench builds the block with FLASH_AW=10, a non-zero BOOT_BASE of 16, RAM_AW=12 and RAM_BASE=0x100. These values show whether the header offset, the payload offset and the RAM offset are each applied. With these small widths the bench can keep the whole flash as one array and predict every RAM write. The cases run are:
- payloads of zero, nine and two hundred bytes;
- an erased length field;
- a corrupted checksum;
- a start pulse issued in the middle of a run.

// File: rtl/bil_pkg.sv
package bil_pkg;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;
  localparam int unsigned HDR_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_VERIFY,
    ST_COPY
  } ld_state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/bil_crc.sv
module bil_crc
  import bil_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clear)   crc_d = CRC_SEED;
    else if (en) crc_d = crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc_out = ~crc_q;
endmodule

// File: rtl/bil_fetch.sv
module bil_fetch #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [31:0]   count,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          dvalid,
  output logic          idle
);
  logic [31:0]   remain_q, remain_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          dvalid_q;

  assign rd_en   = (remain_q != 32'd0);
  assign rd_addr = addr_q;
  assign dvalid  = dvalid_q;
  assign idle    = !rd_en && !dvalid_q;

  always_comb begin
    remain_d = remain_q;
    addr_d   = addr_q;
    if (load) begin
      remain_d = count;
      addr_d   = base;
    end else if (rd_en) begin
      remain_d = remain_q - 32'd1;
      addr_d   = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      addr_q   <= '0;
      dvalid_q <= 1'b0;
    end else begin
      remain_q <= remain_d;
      addr_q   <= addr_d;
      dvalid_q <= rd_en;
    end
  end
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
  import bil_pkg::*;
#(
  parameter int unsigned FLASH_AW  = 16,
  parameter int unsigned RAM_AW    = 16,
  parameter int unsigned BOOT_BASE = 0,
  parameter int unsigned RAM_BASE  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                flash_rd_en,
  output logic [FLASH_AW-1:0] flash_rd_addr,
  input  logic [7:0]          flash_rd_data,
  output logic                ram_wr_en,
  output logic [RAM_AW-1:0]   ram_wr_addr,
  output logic [7:0]          ram_wr_data,
  output logic                busy,
  output logic                done,
  output logic                st_empty,
  output logic                st_crc_fail,
  output logic                st_boot,
  output logic [RAM_AW-1:0]   jump_addr,
  output logic [31:0]         crc_actual,
  output logic [31:0]         crc_expected
);
  localparam logic [FLASH_AW-1:0] HDR_ADDR = FLASH_AW'(BOOT_BASE);
  localparam logic [FLASH_AW-1:0] PAY_ADDR = FLASH_AW'(BOOT_BASE + HDR_BYTES);
  localparam logic [RAM_AW-1:0]   RAM_ORG  = RAM_AW'(RAM_BASE);

  ld_state_t           state_q, state_d;
  logic [63:0]         hdr_q, hdr_d;
  logic [RAM_AW-1:0]   ptr_q, ptr_d;
  logic [RAM_AW-1:0]   waddr_q, waddr_d;
  logic [7:0]          wdata_q, wdata_d;
  logic                we_q, we_d;
  logic                done_q, done_d;
  logic                emp_q, emp_d, fail_q, fail_d, boot_q, boot_d;
  logic [31:0]         act_q, act_d, exp_q, exp_d;

  logic                f_load, f_dvalid, f_idle;
  logic [FLASH_AW-1:0] f_base;
  logic [31:0]         f_count;
  logic                c_clear, c_en;
  logic [31:0]         c_out;
  logic [31:0]         hdr_len, hdr_crc;

  assign hdr_len = hdr_q[63:32];
  assign hdr_crc = hdr_q[31:0];

  bil_fetch #(.AW(FLASH_AW)) u_fetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (f_load),
    .base   (f_base),
    .count  (f_count),
    .rd_en  (flash_rd_en),
    .rd_addr(flash_rd_addr),
    .dvalid (f_dvalid),
    .idle   (f_idle)
  );

  bil_crc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (c_clear),
    .en     (c_en),
    .din    (flash_rd_data),
    .crc_out(c_out)
  );

  always_comb begin
    state_d = state_q;
    hdr_d   = hdr_q;
    ptr_d   = ptr_q;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    done_d  = 1'b0;
    emp_d   = emp_q;
    fail_d  = fail_q;
    boot_d  = boot_q;
    act_d   = act_q;
    exp_d   = exp_q;
    f_load  = 1'b0;
    f_base  = PAY_ADDR;
    f_count = hdr_len;
    c_clear = 1'b0;
    c_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          f_load  = 1'b1;
          f_base  = HDR_ADDR;
          f_count = 32'(HDR_BYTES);
          emp_d   = 1'b0;
          fail_d  = 1'b0;
          boot_d  = 1'b0;
          state_d = ST_HEAD;
        end
      end
      ST_HEAD: begin
        if (f_dvalid) hdr_d = {hdr_q[55:0], flash_rd_data};
        if (f_idle) begin
          if (hdr_len == 32'hFFFF_FFFF) begin
            emp_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            f_load  = 1'b1;
            c_clear = 1'b1;
            state_d = ST_VERIFY;
          end
        end
      end
      ST_VERIFY: begin
        c_en = f_dvalid;
        if (f_idle) begin
          act_d = c_out;
          exp_d = hdr_crc;
          if (c_out == hdr_crc) begin
            f_load  = 1'b1;
            ptr_d   = RAM_ORG;
            state_d = ST_COPY;
          end else begin
            fail_d  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_COPY: begin
        if (f_dvalid) begin
          we_d    = 1'b1;
          waddr_d = ptr_q;
          wdata_d = flash_rd_data;
          ptr_d   = ptr_q + 1'b1;
        end
        if (f_idle && !we_q) begin
          boot_d  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      ptr_q   <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      emp_q   <= 1'b0;
      fail_q  <= 1'b0;
      boot_q  <= 1'b0;
      act_q   <= '0;
      exp_q   <= '0;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      ptr_q   <= ptr_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      done_q  <= done_d;
      emp_q   <= emp_d;
      fail_q  <= fail_d;
      boot_q  <= boot_d;
      act_q   <= act_d;
      exp_q   <= exp_d;
    end
  end

  assign ram_wr_en    = we_q;
  assign ram_wr_addr  = waddr_q;
  assign ram_wr_data  = wdata_q;
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign st_empty     = emp_q;
  assign st_crc_fail  = fail_q;
  assign st_boot      = boot_q;
  assign jump_addr    = boot_q ? RAM_ORG : '0;
  assign crc_actual   = act_q;
  assign crc_expected = exp_q;

  // R4: RAM writes only come out while the copy pass is active
  p_write_in_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> state_q == ST_COPY);

  // R8: one status flag with every done pulse
  p_done_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({st_empty, st_crc_fail, st_boot}) == 1);

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a boot result only follows a matching checksum
  p_boot_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_boot) |-> (crc_actual == crc_expected) && (jump_addr == RAM_ORG));

  // R2: an erased length never reaches the verify pass
  p_empty_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_VERIFY |-> hdr_len != 32'hFFFF_FFFF);

  // R9: no flash traffic while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> !flash_rd_en && !ram_wr_en);
endmodule

// File: tb/test_boot_image_loader.sv
module test_boot_image_loader;
  localparam int FAW = 10;
  localparam int RAW = 12;
  localparam int BB  = 16;
  localparam int RB  = 'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic           flash_rd_en;
  logic [FAW-1:0] flash_rd_addr;
  logic [7:0]     flash_rd_data = 8'h00;
  logic           ram_wr_en;
  logic [RAW-1:0] ram_wr_addr;
  logic [7:0]     ram_wr_data;
  logic busy, done, st_empty, st_crc_fail, st_boot;
  logic [RAW-1:0] jump_addr;
  logic [31:0]    crc_actual, crc_expected;

  always #2.5 clk = ~clk;

  boot_image_loader #(.FLASH_AW(FAW), .RAM_AW(RAW), .BOOT_BASE(BB), .RAM_BASE(RB)) i_boot_image_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .flash_rd_en(flash_rd_en), .flash_rd_addr(flash_rd_addr), .flash_rd_data(flash_rd_data),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
    .busy(busy), .done(done), .st_empty(st_empty), .st_crc_fail(st_crc_fail),
    .st_boot(st_boot), .jump_addr(jump_addr), .crc_actual(crc_actual), .crc_expected(crc_expected)
  );

  logic [7:0] fmem [0:(1<<FAW)-1];
  logic [7:0] pay  [0:255];

  always @(posedge clk) if (flash_rd_en) flash_rd_data <= fmem[flash_rd_addr];

  int tests = 0;
  int fails = 0;
  int reads = 0;
  int dones = 0;
  int cyc = 0;
  logic [19:0] wq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison of the RAM write stream
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (flash_rd_en) reads++;
      if (done) dones++;
      if (ram_wr_en) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R4", "unexpected RAM write", {20'd0, ram_wr_addr}, 32'd0);
        end else begin
          logic [19:0] e;
          e = wq.pop_front();
          chk({ram_wr_addr, ram_wr_data} == e, "R5", "RAM write addr/data",
              {12'd0, ram_wr_addr, ram_wr_data}, {12'd0, e});
        end
      end
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, pay[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic put_image(input logic [31:0] lenf, input logic [31:0] crcf, input int n);
    for (int i = 0; i < 4; i++) begin
      fmem[BB+i]   = lenf[31-8*i -: 8];
      fmem[BB+4+i] = crcf[31-8*i -: 8];
    end
    for (int i = 0; i < n; i++) fmem[BB+8+i] = pay[i];
  endtask

  task automatic run_once(input bit poke_mid);
    reads = 0;
    dones = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_mid) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < 2000 && !done; t++) @(negedge clk);
  endtask

  // R1, R3, R5, R6, R7, R8: good image copied
  task automatic good_case(input int n, input string tag);
    logic [31:0] c;
    c = ref_crc(n);
    put_image(n, c, n);
    for (int i = 0; i < n; i++) wq.push_back({12'(RB + i), pay[i]});
    run_once(1'b0);
    chk(done && st_boot && !st_empty && !st_crc_fail, "R6", {tag, " boot status"},
        {29'd0, st_empty, st_crc_fail, st_boot}, 32'd1);
    chk(jump_addr == RB, "R6", {tag, " jump_addr"}, {20'd0, jump_addr}, RB);
    chk(crc_actual == c && crc_expected == c, "R7", {tag, " crc outputs"}, crc_actual, c);
    chk(reads == 8 + 2*n, "R5", {tag, " flash read count"}, reads, 8 + 2*n);
    @(negedge clk);
    chk(!done && st_boot, "R8", {tag, " done pulse / status hold"}, {30'd0, done, st_boot}, 32'd1);
    chk(wq.size() == 0, "R5", {tag, " all bytes written"}, wq.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < (1<<FAW); i++) fmem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk({flash_rd_en, ram_wr_en, busy, done, st_empty, st_crc_fail, st_boot} == 7'd0,
        "R8", "reset outputs", {25'd0, flash_rd_en, ram_wr_en, busy, done, st_empty, st_crc_fail, st_boot}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: check string
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    good_case(9, "check string");
    chk(crc_actual == 32'hCBF43926, "R3", "CRC of 123456789", crc_actual, 32'hCBF43926);

    // R4, R7: corrupted checksum, no writes
    put_image(9, 32'h12345678, 9);
    run_once(1'b0);
    chk(done && st_crc_fail && !st_boot && !st_empty, "R4", "fail status",
        {29'd0, st_empty, st_crc_fail, st_boot}, 32'd2);
    chk(crc_actual == 32'hCBF43926, "R7", "actual on fail", crc_actual, 32'hCBF43926);
    chk(crc_expected == 32'h12345678, "R1", "expected from big-endian header", crc_expected, 32'h12345678);
    chk(reads == 17, "R4", "reads on fail", reads, 17);
    chk(jump_addr == 0, "R6", "no jump on fail", {20'd0, jump_addr}, 0);

    // R2: erased slot
    put_image(32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    run_once(1'b0);
    chk(done && st_empty && !st_boot && !st_crc_fail, "R2", "empty status",
        {29'd0, st_empty, st_crc_fail, st_boot}, 32'd4);
    chk(reads == 8, "R2", "header-only reads", reads, 8);

    // R3: zero length
    good_case(0, "zero length");
    chk(crc_actual == 32'h0, "R3", "CRC of empty payload", crc_actual, 0);

    // R5: long payload
    for (int i = 0; i < 200; i++) pay[i] = 8'((i * 37 + 11) ^ (i >> 3));
    good_case(200, "long payload");

    // R9: start while busy
    for (int i = 0; i < 20; i++) pay[i] = 8'(i * 5);
    put_image(20, ref_crc(20), 20);
    for (int i = 0; i < 20; i++) wq.push_back({12'(RB + i), pay[i]});
    run_once(1'b1);
    repeat (30) @(negedge clk);
    chk(dones == 1, "R9", "single done pulse", dones, 1);
    chk(!busy && st_boot, "R9", "run ended once", {30'd0, busy, st_boot}, 1);
    chk(reads == 48, "R9", "no second run reads", reads, 48);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule